// File: doc/BRIEF.md
# Rotating-Bank Accumulator Core

This block is a small single-accumulator processor. Every instruction word it fetches is 36 bits wide: a 4-bit opcode sits in bits 35:32 and a 32-bit operand Y sits in bits 31:0. The architectural state is a 14-bit program counter and a 33-bit accumulator. The accumulator is a carry flag C in bit 32 and a 32-bit working register X in bits 31:0. The instruction memory sits outside the core. The core presents the program counter as a fetch address, and the memory answers with the word in the same cycle.

The memory is split into four banks, selected by the two low program-counter bits. A bank pointer advances by one on every clock. An instruction issues only in a cycle where the low program-counter bits equal the bank pointer. Straight-line code therefore runs at one instruction per cycle. After any change of flow, the core idles until the target's bank comes round, exactly as if it were executing a halt.

Random-access reads need no indirect-load path. The exchange-jump instruction loads Y into X and, in the same step, sends the program counter to the old value of X. To fetch a table entry, a program places the table address in X and executes an exchange-jump whose operand is the return address. The table slot itself holds an exchange-jump whose operand is the data. That slot hands the data to X and jumps back.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, the fetch address, X, C and the bank pointer read zero and the halted output is low. This holds whatever state was reached before the reset.
- R2: The bank pointer advances by one modulo 4 on every clock after reset, including stall cycles and halted cycles.
- R3: An instruction issues only when fetch address bits 1:0 equal the bank pointer and the core is not halted. In any cycle without issue, the fetch address, X and C all hold their values.
- R4: Opcode 1 (load) sets X to Y, leaves C unchanged and steps the fetch address by one.
- R5: Opcode 4 (add) writes the 33-bit sum of zero-extended X and Y into {C, X} and steps the fetch address by one.
- R6: Opcode 5 (xor) sets X to X XOR Y, leaves C unchanged and steps the fetch address by one.
- R7: Opcode 2 (exchange-jump) sets the fetch address to bits 13:0 of X as X stood before the instruction, and sets X to Y, both in the same cycle. C is unchanged.
- R8: Opcode 3 (jump) takes its condition from Y[31:28] and its target from Y[13:0]. The conditions are: 0 always, 1 C set, 2 X equal to zero, 3 C clear, 4 X not zero. A jump whose condition fails steps the fetch address by one.
- R9: A jump whose condition code is 5 to 15 is taken unconditionally.
- R10: After a change of flow executed while the bank pointer is b, the target T issues after (T[1:0] - b - 1) mod 4 stall cycles.
- R11: Opcode 0 (halt) raises the halted output. From then until reset, no instruction issues and the fetch address, X and C are frozen.
- R12: Opcodes 6 to 15 only step the fetch address by one; X and C are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetchWord | input | 36 | Memory word at fetchAddr: opcode in 35:32, operand Y in 31:0 |
| fetchAddr | output | 14 | Program counter, used as the fetch address |
| issue | output | 1 | High when the word at fetchAddr executes on the next edge |
| halted | output | 1 | Halt opcode has executed since reset |
| accX | output | 32 | Working register X |
| accC | output | 1 | Carry flag C |
| activeBank | output | 2 | Current bank pointer |

## Verification
Straight-line programs drive load, add, xor and an undefined opcode back to back. These runs separate the add carry-out from the flag-preserving opcodes, and a sequential flow that never stalls from one that stalls spuriously. Jump programs try each condition code both ways, plus an undefined code. Their targets are placed 0, 1 and 3 banks past the rotation, so the measured stall count separates a correct bank wait from an off-by-one. An exchange-jump pair performs a table read through a slot at address 1000. A second exchange-jump starts with high bits set in X, which shows that only the low 14 bits reach the program counter and that the old value of X, not the new one, is used.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    OP_HALT = 4'd0,
    OP_LOAD = 4'd1,
    OP_XJMP = 4'd2,
    OP_JUMP = 4'd3,
    OP_ADD  = 4'd4,
    OP_XOR  = 4'd5
  } opcode_e;

  typedef enum logic [3:0] {
    CC_ALWAYS = 4'd0,
    CC_CSET   = 4'd1,
    CC_XZERO  = 4'd2,
    CC_CCLR   = 4'd3,
    CC_XNZ    = 4'd4
  } cond_e;

  typedef enum logic [1:0] {
    PC_HOLD,
    PC_STEP,
    PC_JUMP,
    PC_SWAP
  } pc_sel_e;

  typedef enum logic [1:0] {
    X_KEEP,
    X_LOADY,
    X_ADD,
    X_XOR
  } x_sel_e;

  typedef struct packed {
    pc_sel_e pcSel;
    x_sel_e  xSel;
    logic    goHalt;
  } ctrl_t;

endpackage

// File: rtl/acc_bank_ring.sv
module acc_bank_ring #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [BANK_W-1:0] bank
);

  localparam logic [BANK_W-1:0] ONE = BANK_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank <= '0;
    else        bank <= bank + ONE;
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int BANK_W = 2
) (
  input  logic [OP_W-1:0]   opcode,
  input  logic [3:0]        condCode,
  input  logic [BANK_W-1:0] pcLow,
  input  logic [BANK_W-1:0] activeBank,
  input  logic              halted,
  input  logic              carry,
  input  logic              xZero,
  output logic              issue,
  output ctrl_t             ctrl
);

  logic taken;

  always_comb begin
    unique case (condCode)
      CC_CSET:  taken = carry;
      CC_XZERO: taken = xZero;
      CC_CCLR:  taken = !carry;
      CC_XNZ:   taken = !xZero;
      default:  taken = 1'b1;
    endcase
  end

  assign issue = !halted && (pcLow == activeBank);

  always_comb begin
    ctrl.pcSel  = PC_HOLD;
    ctrl.xSel   = X_KEEP;
    ctrl.goHalt = 1'b0;
    if (issue) begin
      unique case (opcode)
        OP_HALT: ctrl.goHalt = 1'b1;
        OP_LOAD: begin
          ctrl.xSel  = X_LOADY;
          ctrl.pcSel = PC_STEP;
        end
        OP_XJMP: begin
          ctrl.xSel  = X_LOADY;
          ctrl.pcSel = PC_SWAP;
        end
        OP_JUMP: ctrl.pcSel = taken ? PC_JUMP : PC_STEP;
        OP_ADD: begin
          ctrl.xSel  = X_ADD;
          ctrl.pcSel = PC_STEP;
        end
        OP_XOR: begin
          ctrl.xSel  = X_XOR;
          ctrl.pcSel = PC_STEP;
        end
        default: ctrl.pcSel = PC_STEP;
      endcase
    end
  end

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] operand,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] x,
  output logic              carry,
  output logic              halted,
  output logic              xZero
);

  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

  logic [DATA_W:0]   sum;
  logic [ADDR_W-1:0] pcNext;

  assign sum   = {1'b0, x} + {1'b0, operand};
  assign xZero = (x == '0);

  always_comb begin
    unique case (ctrl.pcSel)
      PC_STEP: pcNext = pc + PC_ONE;
      PC_JUMP: pcNext = operand[ADDR_W-1:0];
      PC_SWAP: pcNext = x[ADDR_W-1:0];
      default: pcNext = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      x      <= '0;
      carry  <= 1'b0;
      halted <= 1'b0;
    end else begin
      pc <= pcNext;
      if (ctrl.goHalt) halted <= 1'b1;
      unique case (ctrl.xSel)
        X_LOADY: x <= operand;
        X_ADD:   {carry, x} <= sum;
        X_XOR:   x <= x ^ operand;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int BANK_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [OP_W+DATA_W-1:0] fetchWord,
  output logic [ADDR_W-1:0]      fetchAddr,
  output logic                   issue,
  output logic                   halted,
  output logic [DATA_W-1:0]      accX,
  output logic                   accC,
  output logic [BANK_W-1:0]      activeBank
);

  localparam int WORD_W = OP_W + DATA_W;

  ctrl_t       ctrl;
  logic        xZero;
  logic [OP_W-1:0]   opcode;
  logic [DATA_W-1:0] operand;

  assign opcode  = fetchWord[WORD_W-1 -: OP_W];
  assign operand = fetchWord[DATA_W-1:0];

  acc_bank_ring #(.BANK_W(BANK_W)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .bank  (activeBank)
  );

  acc_ctrl #(.OP_W(OP_W), .BANK_W(BANK_W)) u_ctrl (
    .opcode     (opcode),
    .condCode   (operand[DATA_W-1 -: 4]),
    .pcLow      (fetchAddr[BANK_W-1:0]),
    .activeBank (activeBank),
    .halted     (halted),
    .carry      (accC),
    .xZero      (xZero),
    .issue      (issue),
    .ctrl       (ctrl)
  );

  acc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .operand (operand),
    .pc      (fetchAddr),
    .x       (accX),
    .carry   (accC),
    .halted  (halted),
    .xZero   (xZero)
  );

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int BANK_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [OP_W+DATA_W-1:0] fetchWord,
  input logic [ADDR_W-1:0]      fetchAddr,
  input logic                   issue,
  input logic                   halted,
  input logic [DATA_W-1:0]      accX,
  input logic                   accC,
  input logic [BANK_W-1:0]      activeBank
);

  localparam int WORD_W = OP_W + DATA_W;

  logic [1:0] upCnt;
  logic       armed;
  logic [OP_W-1:0] op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assign armed = (upCnt >= 2'd2);
  assign op    = fetchWord[WORD_W-1 -: OP_W];

  AST_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    activeBank == BANK_W'($past(activeBank) + 1'b1)); // R2

  AST_ISSUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (fetchAddr[BANK_W-1:0] == activeBank) && !halted); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !issue |=> $stable(fetchAddr) && $stable(accX) && $stable(accC)); // R3

  AST_LOAD_EFFECT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (issue && op == acc_pkg::OP_LOAD) |=>
      accX == $past(fetchWord[DATA_W-1:0]) && accC == $past(accC)
      && fetchAddr == ADDR_W'($past(fetchAddr) + 1'b1)); // R4

  AST_XJMP_SWAP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (issue && op == acc_pkg::OP_XJMP) |=>
      fetchAddr == $past(accX[ADDR_W-1:0]) && accX == $past(fetchWord[DATA_W-1:0])); // R7

  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (issue && op == acc_pkg::OP_JUMP && fetchWord[DATA_W-1 -: 4] == 4'd0) |=>
      fetchAddr == $past(fetchWord[ADDR_W-1:0])); // R8

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    halted |=> halted && $stable(fetchAddr)); // R11

  AST_HALT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !issue); // R11

endmodule

bind acc_core acc_core_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W), .BANK_W(BANK_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetchWord  (fetchWord),
  .fetchAddr  (fetchAddr),
  .issue      (issue),
  .halted     (halted),
  .accX       (accX),
  .accC       (accC),
  .activeBank (activeBank)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] fetchWord = '0;
  logic [13:0] fetchAddr;
  logic        issue;
  logic        halted;
  logic [31:0] accX;
  logic        accC;
  logic [1:0]  activeBank;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [35:0] mem [int unsigned];

  always #2.5 clk = ~clk;

  acc_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchWord  (fetchWord),
    .fetchAddr  (fetchAddr),
    .issue      (issue),
    .halted     (halted),
    .accX       (accX),
    .accC       (accC),
    .activeBank (activeBank)
  );

  function automatic logic [35:0] lookup(input logic [13:0] a);
    int unsigned k;
    k = {18'b0, a};
    if (mem.exists(k)) return mem[k];
    return 36'h0;
  endfunction

  always @(negedge clk) fetchWord = lookup(fetchAddr);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [35:0] mk(input logic [3:0] op, input logic [31:0] y);
    return {op, y};
  endfunction

  function automatic logic [35:0] mkJump(input logic [3:0] cc, input logic [13:0] t);
    return {4'd3, cc, 14'b0, t};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic state(input string req, input logic [13:0] pc, input logic [31:0] x,
                       input logic c);
    chk({req, " pc"}, {18'b0, fetchAddr}, {18'b0, pc});
    chk({req, " x"}, accX, x);
    chk({req, " c"}, {31'b0, accC}, {31'b0, c});
  endtask

  // R1: reset clears state regardless of what the previous scenario left
  task automatic doReset();
    rst_n = 1'b0;
    tick(2);
    state("R1", 14'd0, 32'd0, 1'b0);
    chk("R1 halted", {31'b0, halted}, 32'd0);
    chk("R1 bank", {30'b0, activeBank}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic testStraight();
    mem.delete();
    mem[0] = mk(4'd1, 32'hFFFF_FFFF);
    mem[1] = mk(4'd4, 32'd2);
    mem[2] = mk(4'd5, 32'h0000_00F0);
    mem[3] = mk(4'd1, 32'd5);
    mem[4] = mk(4'd4, 32'd3);
    mem[5] = mk(4'd9, 32'hDEAD_BEEF);
    doReset();
    tick(1); state("R4 load", 14'd1, 32'hFFFF_FFFF, 1'b0);
    chk("R2 bank", {30'b0, activeBank}, 32'd1);
    chk("R3 issue seq", {31'b0, issue}, 32'd1);
    tick(1); state("R5 add carry", 14'd2, 32'd1, 1'b1);
    tick(1); state("R6 xor", 14'd3, 32'hF1, 1'b1);
    tick(1); state("R4 load keeps C", 14'd4, 32'd5, 1'b1);
    tick(1); state("R5 add no carry", 14'd5, 32'd8, 1'b0);
    tick(1); state("R12 undefined op", 14'd6, 32'd8, 1'b0);
    tick(1); chk("R11 halted", {31'b0, halted}, 32'd1);
    tick(2); state("R11 frozen", 14'd6, 32'd8, 1'b0);
    chk("R11 no issue", {31'b0, issue}, 32'd0);
    chk("R2 bank in halt", {30'b0, activeBank}, 32'd1);
  endtask

  task automatic testJumps();
    mem.delete();
    mem[0]  = mk(4'd1, 32'd0);
    mem[1]  = mkJump(4'd2, 14'd9);
    mem[9]  = mk(4'd1, 32'd7);
    mem[10] = mkJump(4'd1, 14'd20);
    mem[11] = mkJump(4'd4, 14'd16);
    mem[16] = mkJump(4'hC, 14'd2);
    mem[2]  = mk(4'd4, 32'hFFFF_FFFF);
    mem[3]  = mkJump(4'd1, 14'd32);
    doReset();
    tick(2); state("R8 X zero taken", 14'd9, 32'd0, 1'b0);
    chk("R10 stall 3 start", {31'b0, issue}, 32'd0);
    tick(2); chk("R10 still stalled", {31'b0, issue}, 32'd0);
    state("R3 hold in stall", 14'd9, 32'd0, 1'b0);
    tick(1); chk("R10 target bank reached", {31'b0, issue}, 32'd1);
    tick(1); state("R10 target ran", 14'd10, 32'd7, 1'b0);
    tick(1); state("R8 C set not taken", 14'd11, 32'd7, 1'b0);
    tick(1); state("R8 X nonzero taken", 14'd16, 32'd7, 1'b0);
    chk("R10 no stall", {31'b0, issue}, 32'd1);
    tick(1); state("R9 undefined cond", 14'd2, 32'd7, 1'b0);
    chk("R10 stall 1", {31'b0, issue}, 32'd0);
    tick(1); chk("R10 stall 1 end", {31'b0, issue}, 32'd1);
    tick(1); state("R5 add wrap", 14'd3, 32'd6, 1'b1);
    tick(1); state("R8 C set taken", 14'd32, 32'd6, 1'b1);
    tick(1); chk("R11 halt at target", {31'b0, halted}, 32'd1);
    tick(2); state("R11 frozen after jump", 14'd32, 32'd6, 1'b1);
  endtask

  task automatic testTableRead();
    mem.delete();
    mem[0]    = mk(4'd1, 32'd1000);
    mem[1]    = mk(4'd2, 32'd2);
    mem[1000] = mk(4'd2, 32'd123);
    doReset();
    tick(2); state("R7 exchange out", 14'd1000, 32'd2, 1'b0);
    tick(2); state("R3 hold before slot", 14'd1000, 32'd2, 1'b0);
    chk("R10 slot bank", {31'b0, issue}, 32'd1);
    tick(1); state("R7 exchange back", 14'd2, 32'd123, 1'b0);
    tick(2); chk("R11 halt after read", {31'b0, halted}, 32'd1);
    chk("R7 data kept", accX, 32'd123);
  endtask

  task automatic testWideX();
    mem.delete();
    mem[0] = mk(4'd1, 32'h1234_4007);
    mem[1] = mk(4'd2, 32'h55);
    doReset();
    tick(2); state("R7 low bits only", 14'd7, 32'h55, 1'b0);
    tick(1); chk("R10 one stall", {31'b0, issue}, 32'd1);
    tick(1); chk("R11 halt", {31'b0, halted}, 32'd1);
  endtask

  initial begin
    testStraight();
    testJumps();
    testTableRead();
    testWideX();
    doReset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule